// File: doc/BRIEF.md
# Sleep-State Power Plane Controller

This block sequences a system between its working state and three sleep depths: a light sleep that only idles the clock generator, a suspend state that removes the main power plane while memory stays powered, and a deep sleep that may also remove the memory plane. A request strobe carries the wanted state. The block drives three active-low sleep strobes that nest by depth, so each deeper state also holds every shallower strobe. Power switching logic outside the block uses these strobes to gate the planes.

While the system sleeps, pins that lead to devices that may lose power are held in a safe condition. Each interface has its own rule. The IDE outputs float or are held low, chosen by a configuration bit. The USB pins are isolated only when USB wake is not enabled. The AC '97 outputs are held low. In every isolated case the input buffers are switched off.

On entry, isolation is applied one clock before the strobes fall. On exit, the strobes rise first and isolation is released two clocks later. A one-cycle acknowledge marks the end of each transition. Requests that arrive while a transition runs are dropped.

Top module: `sleep_plane_ctrl`

## Requirements
- R1: After reset all three sleep strobes are high, `ack` is low, and every interface is in normal operation: each `*_oe` is 1, each `*_dlow` is 0 and each `*_ibe` is 1.
- R2: `req_state` is encoded 0 = working, 1 = S1, 2 = S3, 3 = S4. The strobes nest by depth. In working all are high. S1 drives only `slp1_n` low. S3 drives `slp1_n` and `slp3_n` low. S4 drives all three low. A low `slp4_n` therefore always comes with a low `slp3_n`, and a low `slp3_n` always comes with a low `slp1_n`.
- R3: While isolation is applied, `ide_ibe` is 0. When `ide_lowdrv_cfg` is 1, the IDE outputs are driven low (`ide_oe`=1, `ide_dlow`=1). When it is 0, they float (`ide_oe`=0, `ide_dlow`=0). The configuration bit takes effect at once.
- R4: While isolation is applied and `usb_wake_en` is 0, `usb_oe` and `usb_ibe` are 0. When `usb_wake_en` is 1, the USB pins stay in normal operation. `usb_dlow` is always 0.
- R5: While isolation is applied, the AC '97 outputs are driven low (`ac_oe`=1, `ac_dlow`=1) and `ac_ibe` is 0.
- R6: From working, a sleep request sampled at clock edge k applies isolation after edge k. The strobes for the requested depth, together with `ack`, appear after edge k+1. No strobe is ever low without isolation applied.
- R7: From any sleep state, a working request sampled at edge k raises all strobes after edge k. Isolation is released, with `ack`, after edge k+2.
- R8: A request from one sleep state to another changes the strobes after the edge that samples it and raises `ack` for that cycle, with isolation kept. A request for the current state only pulses `ack`.
- R9: A request is ignored while an entry or exit sequence is in progress and in the cycle in which `ack` is high.
- R10: `ack` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_state | input | 2 | Requested state (0 working, 1 S1, 2 S3, 3 S4) |
| usb_wake_en | input | 1 | USB wake enabled; keeps the USB pins live in sleep |
| ide_lowdrv_cfg | input | 1 | 1: IDE outputs driven low in sleep; 0: floated |
| slp1_n | output | 1 | Light-sleep strobe, active low |
| slp3_n | output | 1 | Main-plane-off strobe, active low |
| slp4_n | output | 1 | Memory-plane-off strobe, active low |
| ack | output | 1 | One-cycle transition-complete pulse |
| ide_oe | output | 1 | IDE output enable |
| ide_dlow | output | 1 | IDE force-low |
| ide_ibe | output | 1 | IDE input buffer enable |
| usb_oe | output | 1 | USB output enable |
| usb_dlow | output | 1 | USB force-low (always 0) |
| usb_ibe | output | 1 | USB input buffer enable |
| ac_oe | output | 1 | AC '97 output enable |
| ac_dlow | output | 1 | AC '97 force-low |
| ac_ibe | output | 1 | AC '97 input buffer enable |

## Verification
The assertions check on every cycle that the strobes nest, that no strobe falls without isolation already in place, that isolation outlasts the rising strobes by two cycles, that `ack` never lasts two cycles, and that each interface's pins stay consistent with its isolation rule. Only the bench scenarios can show the exact cycle on which each step of entry and exit lands, the strobe pattern for each requested depth, and the dropping of requests made during a transition. They also cover the live effect of the wake and IDE configuration inputs.

// File: rtl/sleep_plane_pkg.sv
package sleep_plane_pkg;

  typedef enum logic [1:0] {
    PWR_WORK = 2'd0,
    PWR_S1   = 2'd1,
    PWR_S3   = 2'd2,
    PWR_S4   = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTER = 2'd1,
    SEQ_EXIT1 = 2'd2,
    SEQ_EXIT2 = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PORT_IDE = 2'd0,
    PORT_USB = 2'd1,
    PORT_AC  = 2'd2
  } port_kind_e;

  localparam int unsigned STROBE_N = 3;

endpackage

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_plane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  pwr_state_e req_state,
  output pwr_state_e cur_state,
  output logic       iso_on,
  output logic       ack
);

  seq_state_e seq_q, seq_d;
  pwr_state_e cur_q, cur_d;
  pwr_state_e tgt_q, tgt_d;
  logic       iso_q, iso_d;
  logic       ack_q, ack_d;
  logic       accept;
  logic       tgt_en;

  assign accept = (seq_q == SEQ_IDLE) && req_valid && !ack_q;

  // next-state process
  always_comb begin
    seq_d  = seq_q;
    cur_d  = cur_q;
    tgt_d  = tgt_q;
    iso_d  = iso_q;
    ack_d  = 1'b0;
    tgt_en = 1'b0;
    unique case (seq_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (req_state == cur_q) begin
            ack_d = 1'b1;
          end else if (cur_q == PWR_WORK) begin
            iso_d  = 1'b1;
            tgt_d  = req_state;
            tgt_en = 1'b1;
            seq_d  = SEQ_ENTER;
          end else if (req_state == PWR_WORK) begin
            cur_d = PWR_WORK;
            seq_d = SEQ_EXIT1;
          end else begin
            cur_d = req_state;
            ack_d = 1'b1;
          end
        end
      end
      SEQ_ENTER: begin
        cur_d = tgt_q;
        ack_d = 1'b1;
        seq_d = SEQ_IDLE;
      end
      SEQ_EXIT1: begin
        seq_d = SEQ_EXIT2;
      end
      SEQ_EXIT2: begin
        iso_d = 1'b0;
        ack_d = 1'b1;
        seq_d = SEQ_IDLE;
      end
      default: seq_d = SEQ_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      cur_q <= PWR_WORK;
      iso_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      seq_q <= seq_d;
      cur_q <= cur_d;
      iso_q <= iso_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= PWR_WORK;
    end else if (tgt_en) begin
      tgt_q <= tgt_d;
    end
  end

  assign cur_state = cur_q;
  assign iso_on    = iso_q;
  assign ack       = ack_q;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10

  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q == SEQ_EXIT1) |=> (seq_q == SEQ_EXIT2) && iso_q); // R9

  AST_SLEEP_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != PWR_WORK) |-> iso_q); // R6

endmodule

// File: rtl/slp_strobe_dec.sv
module slp_strobe_dec
  import sleep_plane_pkg::*;
(
  input  pwr_state_e          depth,
  output logic [STROBE_N-1:0] strobe_n
);

  // strobe i is active for every depth at or beyond level i+1
  for (genvar i = 0; i < STROBE_N; i++) begin : g_lvl
    assign strobe_n[i] = !(depth > pwr_state_e'(i));
  end

endmodule

// File: rtl/port_isolator.sv
module port_isolator
  import sleep_plane_pkg::*;
#(
  parameter port_kind_e KIND = PORT_IDE
) (
  input  logic iso_on,
  input  logic mode_sel,
  output logic oe,
  output logic dlow,
  output logic ibe
);

  if (KIND == PORT_IDE) begin : g_ide
    // mode_sel: 1 hold low, 0 float
    assign oe   = !iso_on || mode_sel;
    assign dlow = iso_on && mode_sel;
    assign ibe  = !iso_on;
  end else if (KIND == PORT_USB) begin : g_usb
    // mode_sel: wake enabled keeps the port live
    logic cut;
    assign cut  = iso_on && !mode_sel;
    assign oe   = !cut;
    assign dlow = 1'b0;
    assign ibe  = !cut;
  end else begin : g_ac
    logic unused_sel;
    assign unused_sel = mode_sel;
    assign oe   = 1'b1;
    assign dlow = iso_on;
    assign ibe  = !iso_on;
  end

  always_comb begin
    if (!ibe) begin
      AST_ISO_FLOAT_OR_LOW: assert (!oe || dlow); // R3
    end
  end

endmodule

// File: rtl/sleep_plane_ctrl.sv
module sleep_plane_ctrl
  import sleep_plane_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  input  logic       usb_wake_en,
  input  logic       ide_lowdrv_cfg,
  output logic       slp1_n,
  output logic       slp3_n,
  output logic       slp4_n,
  output logic       ack,
  output logic       ide_oe,
  output logic       ide_dlow,
  output logic       ide_ibe,
  output logic       usb_oe,
  output logic       usb_dlow,
  output logic       usb_ibe,
  output logic       ac_oe,
  output logic       ac_dlow,
  output logic       ac_ibe
);

  pwr_state_e          cur_state;
  logic                iso_on;
  logic [STROBE_N-1:0] strobe_n;

  sleep_seq_fsm i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_state (pwr_state_e'(req_state)),
    .cur_state (cur_state),
    .iso_on    (iso_on),
    .ack       (ack)
  );

  slp_strobe_dec i_dec (
    .depth    (cur_state),
    .strobe_n (strobe_n)
  );

  assign slp1_n = strobe_n[0];
  assign slp3_n = strobe_n[1];
  assign slp4_n = strobe_n[2];

  port_isolator #(.KIND(PORT_IDE)) i_ide (
    .iso_on (iso_on), .mode_sel (ide_lowdrv_cfg),
    .oe (ide_oe), .dlow (ide_dlow), .ibe (ide_ibe)
  );

  port_isolator #(.KIND(PORT_USB)) i_usb (
    .iso_on (iso_on), .mode_sel (usb_wake_en),
    .oe (usb_oe), .dlow (usb_dlow), .ibe (usb_ibe)
  );

  port_isolator #(.KIND(PORT_AC)) i_ac (
    .iso_on (iso_on), .mode_sel (1'b0),
    .oe (ac_oe), .dlow (ac_dlow), .ibe (ac_ibe)
  );

  AST_NEST_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !slp4_n |-> !slp3_n); // R2

  AST_NEST_MID: assert property (@(posedge clk) disable iff (!rst_n)
    !slp3_n |-> !slp1_n); // R2

  AST_ISO_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp1_n) |-> $past(!ac_ibe)); // R6

  AST_ISO_OUTLASTS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp1_n) |=> !ac_ibe); // R7

  AST_USB_WAKE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    usb_wake_en |-> (usb_oe && usb_ibe && !usb_dlow)); // R4

  AST_AC_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_ibe |-> (ac_oe && ac_dlow)); // R5

endmodule

// File: tb/test_sleep_plane_ctrl.sv
`timescale 1ns/1ps
module test_sleep_plane_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_state;
  logic usb_wake_en;
  logic ide_lowdrv_cfg;
  logic slp1_n, slp3_n, slp4_n, ack;
  logic ide_oe, ide_dlow, ide_ibe, usb_oe, usb_dlow, usb_ibe, ac_oe, ac_dlow, ac_ibe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sleep_plane_ctrl i_sleep_plane_ctrl (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_state (req_state),
    .usb_wake_en (usb_wake_en), .ide_lowdrv_cfg (ide_lowdrv_cfg),
    .slp1_n (slp1_n), .slp3_n (slp3_n), .slp4_n (slp4_n), .ack (ack),
    .ide_oe (ide_oe), .ide_dlow (ide_dlow), .ide_ibe (ide_ibe),
    .usb_oe (usb_oe), .usb_dlow (usb_dlow), .usb_ibe (usb_ibe),
    .ac_oe (ac_oe), .ac_dlow (ac_dlow), .ac_ibe (ac_ibe)
  );

  // {slp4_n, slp3_n, slp1_n, ack}
  function automatic logic [3:0] exp_strb(input logic [1:0] st, input logic a);
    logic [2:0] s;
    case (st)
      2'd0: s = 3'b111;
      2'd1: s = 3'b110;
      2'd2: s = 3'b100;
      default: s = 3'b000;
    endcase
    return {s, a};
  endfunction

  // {ide oe,dlow,ibe, usb oe,dlow,ibe, ac oe,dlow,ibe}
  function automatic logic [8:0] exp_iso(input logic iso, input logic cfg, input logic wake);
    logic [2:0] ide, usb, ac;
    ide = !iso ? 3'b101 : (cfg ? 3'b110 : 3'b000);
    usb = (iso && !wake) ? 3'b000 : 3'b101;
    ac  = iso ? 3'b110 : 3'b101;
    return {ide, usb, ac};
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_s(input string tag, input logic [1:0] st, input logic a);
    chk(tag, {5'b0, slp4_n, slp3_n, slp1_n, ack}, {5'b0, exp_strb(st, a)});
  endtask

  task automatic chk_i(input string tag, input logic iso);
    chk(tag, {ide_oe, ide_dlow, ide_ibe, usb_oe, usb_dlow, usb_ibe, ac_oe, ac_dlow, ac_ibe},
        exp_iso(iso, ide_lowdrv_cfg, usb_wake_en));
  endtask

  // request sampled at one edge; returns just after that edge
  task automatic send(input logic [1:0] st);
    @(negedge clk);
    req_valid = 1'b1;
    req_state = st;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk_s("R1 strobes/ack after reset", 2'd0, 1'b0);
    chk_i("R1 interfaces after reset", 1'b0);
  endtask

  task automatic t_enter(input logic [1:0] st);
    send(st);
    chk_s("R6 strobes still high one clock after request", 2'd0, 1'b0);
    chk_i("R6 isolation applied after sampling edge", 1'b1);
    @(negedge clk);
    chk_s("R2 R6 strobe pattern with ack", st, 1'b1);
    chk_i("R3 R4 R5 isolation in sleep", 1'b1);
    @(negedge clk);
    chk_s("R10 ack drops after one cycle", st, 1'b0);
  endtask

  task automatic t_exit(input logic [1:0] from);
    send(2'd0);
    chk_s("R7 strobes rise first", 2'd0, 1'b0);
    chk_i("R7 isolation held after strobes rise", 1'b1);
    @(negedge clk);
    chk_i("R7 isolation held second cycle", 1'b1);
    chk_s("R7 no ack yet", 2'd0, 1'b0);
    @(negedge clk);
    chk_i("R7 isolation released", 1'b0);
    chk_s("R7 ack with release", 2'd0, 1'b1);
    @(negedge clk);
    chk_s("R10 ack single cycle on exit", 2'd0, 1'b0);
    if (from == 2'd0) n_bad++;
  endtask

  task automatic t_s2s(input logic [1:0] from, input logic [1:0] to);
    send(to);
    chk_s("R8 sleep-to-sleep strobe change with ack", to, 1'b1);
    chk_i("R8 isolation kept between sleep states", 1'b1);
    @(negedge clk);
    chk_s("R8 R10 ack cleared", to, 1'b0);
    if (from == to) begin
      send(to);
      chk_s("R8 same-state request only pulses ack", to, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic t_busy();
    @(negedge clk);
    req_valid = 1'b1;
    req_state = 2'd3;
    @(negedge clk);
    req_state = 2'd1;  // sampled in entry sequence
    @(negedge clk);    // sampled while ack high
    @(negedge clk);
    req_valid = 1'b0;
    chk_s("R9 requests during transition ignored", 2'd3, 1'b0);
    chk_i("R9 isolation remains", 1'b1);
  endtask

  task automatic t_cfg();
    ide_lowdrv_cfg = 1'b0;
    #1 chk_i("R3 IDE float mode in sleep", 1'b1);
    chk(ide_ibe ? "R3 ibe" : "R3 ibe", {8'b0, ide_oe}, 9'd0);
    ide_lowdrv_cfg = 1'b1;
    #1 chk_i("R3 IDE drive-low mode in sleep", 1'b1);
    usb_wake_en = 1'b1;
    #1 chk_i("R4 USB live with wake enabled", 1'b1);
    chk("R4 usb_oe with wake", {8'b0, usb_oe}, 9'd1);
    usb_wake_en = 1'b0;
    #1 chk("R4 usb isolated without wake", {7'b0, usb_oe, usb_ibe}, 9'd0);
    chk("R5 AC held low", {6'b0, ac_oe, ac_dlow, ac_ibe}, 9'b110);
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_state = 2'd0;
    usb_wake_en = 1'b0;
    ide_lowdrv_cfg = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enter(2'd2);
    t_cfg();
    t_s2s(2'd2, 2'd3);
    t_s2s(2'd3, 2'd1);
    t_s2s(2'd1, 2'd1);
    t_exit(2'd1);
    ide_lowdrv_cfg = 1'b0;
    usb_wake_en = 1'b1;
    t_enter(2'd1);
    t_exit(2'd1);
    usb_wake_en = 1'b0;
    t_enter(2'd3);
    t_exit(2'd3);
    t_busy();
    t_exit(2'd3);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule